// File: doc/BRIEF.md
# Single-Precision Compare and Move Unit

This unit takes two 32-bit IEEE single-precision operands and a small operation code. It performs one of five operations: an ordered comparison, a comparison that also flags every unordered outcome, a plain copy, an absolute value, or a sign flip. A comparison yields a two-bit floating condition code, which a status register would hold in its bits 11:10. It also yields a five-bit exception vector, in which only the invalid flag can be set. The copy-style operations yield a 32-bit result word and never raise an exception.

Each operation is accepted on a cycle where `in_valid` is high. All outputs are registered and appear one clock later, marked by `out_valid`. The condition-code write strobe is raised only for comparisons, because there is a single condition-code set to write. Between accepted operations the outputs keep their last values.

Top module: `sp_cmpmov_unit`

## Requirements
- R1: Every operation accepted with `in_valid` high shows `out_valid` high on exactly the next clock. `out_valid` is low on any cycle that follows a cycle with `in_valid` low, and the data outputs then keep their previous values.
- R2: A comparison sets `fcc` as follows: 0 when rs1 equals rs2, 1 when rs1 < rs2, 2 when rs1 > rs2, and 3 when the pair is unordered.
- R3: Positive zero (0x00000000) and negative zero (0x80000000) compare equal (`fcc` = 0), in either operand order.
- R4: An operand is a NaN when its exponent bits 30:23 are all ones and its fraction bits 22:0 are nonzero. It is signaling when bit 22 is zero. Infinities are ordered: +inf is greater than every finite value.
- R5: The plain compare (op 0) sets invalid (`exc` bit 4, value 5'b10000) on an unordered result only if an operand is a signaling NaN. Otherwise `exc` is 0.
- R6: The exception compare (op 1) sets invalid (`exc` = 5'b10000) on every unordered result, quiet NaNs included. Ordered results give `exc` = 0.
- R7: Move (op 2) returns rs2 unchanged, absolute value (op 3) returns rs2 with bit 31 cleared, and negate (op 4) returns rs2 with bit 31 inverted. Codes 5 to 7 behave as move.
- R8: Non-compare operations give `exc` = 0, `fcc_we` = 0 and `fcc` = 0. Comparisons give `fcc_we` = 1 and `result` = 0.
- R9: A synchronous reset clears `out_valid`, `result`, `fcc`, `fcc_we` and `exc` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | 0 compare, 1 exception compare, 2 move, 3 abs, 4 negate |
| rs1 | input | 32 | First operand (compares only) |
| rs2 | input | 32 | Second operand / source of copy operations |
| out_valid | output | 1 | Registered result strobe |
| result | output | 32 | Result word of copy operations |
| fcc | output | 2 | Floating condition code |
| fcc_we | output | 1 | Condition-code write enable |
| exc | output | 5 | Exception vector, bit 4 = invalid |

## Verification
Every result of this unit, whether condition code, exception vector or result word, is due exactly one clock after the accepting edge. The driver changes inputs on falling edges and places one expected item per accepted operation in a queue. The monitor reads the outputs two nanoseconds after each rising edge. It pops an item whenever `out_valid` is high and fails if `out_valid` appears with an empty queue, so any added or missing cycle of latency is caught. Idle gaps and back-to-back strobes are mixed in, so the bench also checks that the outputs hold their values through idle cycles.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [2:0] {
    OP_CMP  = 3'd0,
    OP_CMPX = 3'd1,
    OP_MOV  = 3'd2,
    OP_ABS  = 3'd3,
    OP_NEG  = 3'd4
  } fcm_op_e;

  localparam int EXC_W   = 5;
  localparam int EXC_INV = 4;

  localparam logic [1:0] FCC_EQ = 2'd0;
  localparam logic [1:0] FCC_LT = 2'd1;
  localparam logic [1:0] FCC_GT = 2'd2;
  localparam logic [1:0] FCC_UN = 2'd3;
endpackage

// File: rtl/fcm_classify.sv
module fcm_classify #(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8
) (
  input  logic [WIDTH-1:0] val,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_zero,
  output logic             sign,
  output logic [WIDTH-2:0] mag
);
  localparam int FRAC_W = WIDTH - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f   = val[WIDTH-2 -: EXP_W];
    frac_f  = val[FRAC_W-1:0];
    sign    = val[WIDTH-1];
    mag     = val[WIDTH-2:0];
    is_nan  = (&exp_f) && (|frac_f);
    is_snan = is_nan && !frac_f[FRAC_W-1];
    is_zero = (mag == '0);
  end
endmodule

// File: rtl/fcm_compare.sv
module fcm_compare
  import fcm_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [1:0]       code,
  output logic             unord,
  output logic             any_snan
);
  localparam int NOPS = 2;

  logic [NOPS-1:0]  nan_v, snan_v, zero_v, sign_v;
  logic [WIDTH-2:0] mag_v [NOPS];
  logic [WIDTH-1:0] opnd  [NOPS];

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fcm_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls (
      .val     (opnd[i]),
      .is_nan  (nan_v[i]),
      .is_snan (snan_v[i]),
      .is_zero (zero_v[i]),
      .sign    (sign_v[i]),
      .mag     (mag_v[i])
    );
  end

  logic mag_lt, mag_eq;

  always_comb begin
    unord    = |nan_v;
    any_snan = |snan_v;
    mag_lt   = mag_v[0] < mag_v[1];
    mag_eq   = mag_v[0] == mag_v[1];
    if (unord)
      code = FCC_UN;
    else if (&zero_v)
      code = FCC_EQ;
    else if (sign_v[0] != sign_v[1])
      code = sign_v[0] ? FCC_LT : FCC_GT;
    else if (mag_eq)
      code = FCC_EQ;
    else if (mag_lt ^ sign_v[0])
      code = FCC_LT;
    else
      code = FCC_GT;
  end
endmodule

// File: rtl/fcm_move.sv
module fcm_move
  import fcm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  always_comb begin
    dst = src;
    if (op == OP_ABS)
      dst[WIDTH-1] = 1'b0;
    else if (op == OP_NEG)
      dst[WIDTH-1] = ~src[WIDTH-1];
  end
endmodule

// File: rtl/sp_cmpmov_unit.sv
module sp_cmpmov_unit
  import fcm_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] rs1,
  input  logic [WIDTH-1:0] rs2,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       fcc,
  output logic             fcc_we,
  output logic [EXC_W-1:0] exc
);
  logic [1:0]       cmp_code;
  logic             cmp_unord, cmp_snan;
  logic [WIDTH-1:0] mov_word;
  logic             is_cmp, raise_inv;
  logic [EXC_W-1:0] exc_next;

  fcm_compare #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cmp (
    .a        (rs1),
    .b        (rs2),
    .code     (cmp_code),
    .unord    (cmp_unord),
    .any_snan (cmp_snan)
  );

  fcm_move #(.WIDTH(WIDTH)) u_mov (
    .op  (op),
    .src (rs2),
    .dst (mov_word)
  );

  always_comb begin
    is_cmp    = (op == OP_CMP) || (op == OP_CMPX);
    raise_inv = is_cmp && cmp_unord && ((op == OP_CMPX) || cmp_snan);
    exc_next  = '0;
    exc_next[EXC_INV] = raise_inv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      fcc       <= '0;
      fcc_we    <= 1'b0;
      exc       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= is_cmp ? '0 : mov_word;
        fcc    <= is_cmp ? cmp_code : 2'd0;
        fcc_we <= is_cmp;
        exc    <= exc_next;
      end else begin
        fcc_we <= 1'b0;
      end
    end
  end

  // R1: one-cycle latency of the strobe
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: write strobe only with a valid result
  p_we_valid_r8: assert property (@(posedge clk) disable iff (rst)
    fcc_we |-> out_valid);
  // R5/R6: invalid only reported for an unordered compare
  p_inv_unord_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc != '0) |-> (fcc_we && fcc == FCC_UN));
  // R7: absolute value clears the sign bit
  p_abs_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ABS) |=> !result[WIDTH-1]);
  // R7: negate flips the sign bit and keeps the rest
  p_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_NEG) |=>
      (result == {~$past(rs2[WIDTH-1]), $past(rs2[WIDTH-2:0])}));
  // R8: copy-style operations raise nothing
  p_mov_noexc_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(op == OP_CMP || op == OP_CMPX)) |=> (exc == '0 && !fcc_we));
endmodule

// File: tb/tb_sp_cmpmov_unit.sv
module tb_sp_cmpmov_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] rs1, rs2;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  fcc;
  logic        fcc_we;
  logic [4:0]  exc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] res;
    logic [1:0]  cc;
    logic        we;
    logic [4:0]  ex;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  sp_cmpmov_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rs1(rs1), .rs2(rs2),
    .out_valid(out_valid), .result(result), .fcc(fcc), .fcc_we(fcc_we), .exc(exc)
  );

  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic [31:0] m_key(input logic [31:0] x);
    logic [31:0] y;
    y = (x == 32'h8000_0000) ? 32'h0 : x;
    return y[31] ? ~y : (y | 32'h8000_0000);
  endfunction

  function automatic exp_t model(input logic [2:0] o, input logic [31:0] a,
                                 input logic [31:0] b, input string tag);
    exp_t e;
    bit un, sn;
    e.tag = tag; e.res = 32'h0; e.cc = 2'd0; e.we = 1'b0; e.ex = 5'd0;
    if (o == 3'd0 || o == 3'd1) begin
      e.we = 1'b1;
      un = m_nan(a) || m_nan(b);
      sn = (m_nan(a) && !a[22]) || (m_nan(b) && !b[22]);
      if (un) e.cc = 2'd3;
      else if (m_key(a) == m_key(b)) e.cc = 2'd0;
      else if (m_key(a) < m_key(b)) e.cc = 2'd1;
      else e.cc = 2'd2;
      if (un && (o == 3'd1 || sn)) e.ex = 5'b10000;
    end else if (o == 3'd3) e.res = {1'b0, b[30:0]};
    else if (o == 3'd4) e.res = b ^ 32'h8000_0000;
    else e.res = b;
    return e;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; rs1 = a; rs2 = b;
    sb.push_back(model(o, a, b, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 3'd7; rs1 = 32'hDEAD_BEEF; rs2 = 32'h1234_5678;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (out_valid) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R1: out_valid=1 with nothing expected");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (result !== e.res || fcc !== e.cc || fcc_we !== e.we || exc !== e.ex) begin
            bad++;
            $display("FAIL %s: got res=%h fcc=%0d we=%0b exc=%b exp res=%h fcc=%0d we=%0b exc=%b",
                     e.tag, result, fcc, fcc_we, exc, e.res, e.cc, e.we, e.ex);
          end
        end
      end else if (fcc_we !== 1'b0) begin
        total++; bad++;
        $display("FAIL R8: fcc_we=%0b without out_valid exp 0", fcc_we);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; in_valid = 1'b0; op = 3'd0; rs1 = 32'h0; rs2 = 32'h0;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 0 || result !== 0 || fcc !== 0 || fcc_we !== 0 || exc !== 0) begin
      bad++;
      $display("FAIL R9: got v=%0b res=%h fcc=%0d we=%0b exc=%b exp all zero",
               out_valid, result, fcc, fcc_we, exc);
    end
    rst = 1'b0;
    idle(2);
    drive(3'd0, 32'h3F80_0000, 32'h4000_0000, "R2 lt");
    drive(3'd0, 32'h4000_0000, 32'h3F80_0000, "R2 gt");
    drive(3'd1, 32'h4040_0000, 32'h4040_0000, "R2 eq");
    idle(1);
    drive(3'd0, 32'h0000_0000, 32'h8000_0000, "R3 +0/-0");
    drive(3'd1, 32'h8000_0000, 32'h0000_0000, "R3 -0/+0");
    drive(3'd0, 32'hBF80_0000, 32'hC000_0000, "R2 neg gt");
    drive(3'd0, 32'hBF80_0000, 32'h3F80_0000, "R2 sign lt");
    drive(3'd0, 32'h7F80_0000, 32'h3F80_0000, "R4 inf gt");
    drive(3'd1, 32'hFF80_0000, 32'h7F80_0000, "R4 -inf lt");
    drive(3'd0, 32'h7FC0_0000, 32'h3F80_0000, "R5 qnan quiet");
    drive(3'd0, 32'h3F80_0000, 32'h7F80_0001, "R5 snan invalid");
    drive(3'd1, 32'h7FC0_0000, 32'h3F80_0000, "R6 qnan invalid");
    drive(3'd1, 32'h3F80_0000, 32'hFFA0_0000, "R6 snan invalid");
    drive(3'd2, 32'h1111_1111, 32'hC049_0FDB, "R7 move");
    drive(3'd3, 32'h0, 32'hC049_0FDB, "R7 abs");
    drive(3'd4, 32'h0, 32'hC049_0FDB, "R7 neg");
    drive(3'd4, 32'h0, 32'h0000_0000, "R7 neg zero");
    drive(3'd2, 32'h7FC0_0000, 32'h7F80_0001, "R8 move of nan");
    drive(3'd6, 32'h0, 32'h5555_AAAA, "R7 code6");
    idle(3);
    // R1: outputs hold through idle cycles
    held = 32'h5555_AAAA;
    total++;
    if (out_valid !== 0 || result !== held) begin
      bad++;
      $display("FAIL R1: idle got v=%0b res=%h exp v=0 res=%h", out_valid, result, held);
    end
    idle(2);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R1: %0d results missing exp 0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule